// File: doc/BRIEF.md
# Linked-Descriptor Transmit DMA Engine

This block moves outgoing frame data from memory to a byte stream. Software builds a chain of descriptors in memory. Each descriptor is four 32-bit words at consecutive word addresses. The word at offset +0 is the status word and carries the ownership flag. The word at +4 is the control word: segment length, segment markers and an enable flag. The word at +8 is the start address of the data buffer, and the word at +12 is the address of the next descriptor. Software hands a descriptor to the engine by setting its ownership flag. The engine reads the data buffer, pushes the bytes into an internal byte queue and returns the descriptor by writing the status word back with the ownership flag cleared. It then moves on to the address held in the next field. A chain usually closes on itself, so once the engine has gone all the way round it meets a returned descriptor and parks there.

Software controls the engine through two write-only registers. The control register holds the run flag, a poll kick that clears itself and a store-and-forward selector. The base register holds the address of the first descriptor. The queue drains onto a valid/ready byte stream that marks the first and last bytes of each frame. Memory is reached through one request/acknowledge port that has a single access outstanding at a time.

Top module: `txdma_fetch`

## Requirements
- R1: After reset the engine makes no memory request and `tx_valid` is low until software sets the run flag.
- R2: Writing a 1 to bit 30 of the control register (`cfg_sel`=0) while the run flag is clear starts the engine. It loads the descriptor pointer from the base register (`cfg_sel`=1), and its first memory read is the status word at that address.
- R3: A descriptor whose status bit 31 is 0 is not DMA-owned. The engine reads only its status word, writes nothing to memory, emits no byte and parks on that descriptor.
- R4: While parked, the engine makes no memory access until a control write with bit 31 set (the poll kick). The kick makes it re-read the status word of the same descriptor.
- R5: A descriptor whose control bit 24 is 0 is treated as not ready. After reading the status and control words, the engine parks on it as in R3, leaves its status word unchanged and emits nothing.
- R6: The segment length is control bits [LEN_W-1:0], a count of bytes. The engine sends exactly that many bytes from a word-aligned buffer. The bytes go out in ascending address order, and byte k of a word is bits [8k+7:8k] (little-endian). A length of 0 sends nothing.
- R7: `tx_first` is high on the first byte of a segment whose control bit 29 is set. `tx_last` is high on the final byte of a segment whose control bit 30 is set. Both are low on every other byte.
- R8: Once every byte of a segment is in the queue, the engine writes the status word back to the descriptor address. Bit 31 is cleared and the other bits are left as they were read.
- R9: After the write-back, the next descriptor fetched is the one at the address in the next field. A chain that points back to its head is followed round to the head again.
- R10: With control bit 1 set (store-and-forward), no byte of a frame appears on the stream until that frame's last-marked byte is in the queue. With bit 1 clear, bytes leave as soon as they are queued.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data`, `tx_first` and `tx_last` hold their values.
- R12: A memory request holds `mem_req`, `mem_addr` and `mem_we` steady until the cycle it is acknowledged.
- R13: Clearing the run flag stops the engine at the next descriptor boundary. The segment in progress is finished and written back, and the next descriptor is not read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 control, 1 base address |
| cfg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write (status write-back) |
| mem_addr | output | ADDR_W | Byte address of the word accessed |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| tx_valid | output | 1 | Stream byte available |
| tx_ready | input | 1 | Sink accepts the byte |
| tx_data | output | 8 | Stream byte |
| tx_first | output | 1 | First byte of a frame |
| tx_last | output | 1 | Last byte of a frame |

## Verification
Random chains of two to five descriptors are run against random memory latency and random sink back-pressure, in both queue modes. Frames span one to three segments and carry random status bits, which separates faults in byte ordering, length counting, marker placement and status write-back from faults in pointer following. Directed cases cover a chain that ends on an unowned descriptor and a descriptor without the enable flag. Around them, counts of memory reads confirm that parking stops all traffic until a kick and that stopping halts at a descriptor boundary. A single long frame with a fixed slow memory is timed in each queue mode: the first output byte must come after the last buffer fetch in store-and-forward mode, and before it in cut-through mode.

// File: rtl/txd_pkg.sv
package txd_pkg;

    localparam int WORD_W        = 32;
    localparam int OWN_BIT       = 31;
    localparam int SEG_LAST_BIT  = 30;
    localparam int SEG_FIRST_BIT = 29;
    localparam int SEG_ENA_BIT   = 24;
    localparam int CTL_KICK_BIT  = 31;
    localparam int CTL_RUN_BIT   = 30;
    localparam int CTL_SF_BIT    = 1;
    localparam logic [WORD_W-1:0] OWN_MASK = WORD_W'(1) << OWN_BIT;

    typedef enum logic [3:0] {
        W_IDLE,
        W_RD_STAT,
        W_RD_CTRL,
        W_RD_BUF,
        W_RD_NEXT,
        W_RD_DATA,
        W_PUSH,
        W_WB,
        W_SUSP
    } walk_state_t;

    typedef struct packed {
        logic [7:0] data;
        logic       first;
        logic       last;
    } tx_ent_t;

    function automatic logic [7:0] lane_byte(input logic [WORD_W-1:0] w, input logic [1:0] sel);
        return w[8*sel +: 8];
    endfunction

endpackage

// File: rtl/txd_regs.sv
module txd_regs
    import txd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic              run,
    output logic              sf_mode,
    output logic              kick,
    output logic              start,
    output logic [ADDR_W-1:0] base
);

    always_ff @(posedge clk) begin
        if (rst) begin
            run     <= 1'b0;
            sf_mode <= 1'b0;
            kick    <= 1'b0;
            start   <= 1'b0;
            base    <= '0;
        end else begin
            kick  <= 1'b0;
            start <= 1'b0;
            if (cfg_wr && !cfg_sel) begin
                run     <= cfg_wdata[CTL_RUN_BIT];
                sf_mode <= cfg_wdata[CTL_SF_BIT];
                kick    <= cfg_wdata[CTL_KICK_BIT];
                start   <= cfg_wdata[CTL_RUN_BIT] && !run;
            end
            if (cfg_wr && cfg_sel) begin
                base <= cfg_wdata[ADDR_W-1:0];
            end
        end
    end

endmodule

// File: rtl/txd_walker.sv
module txd_walker
    import txd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              start,
    input  logic              kick,
    input  logic [ADDR_W-1:0] base,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              push,
    output tx_ent_t           push_ent,
    input  logic              q_full
);

    walk_state_t        state;
    logic [ADDR_W-1:0]  cur;
    logic [ADDR_W-1:0]  buf_q;
    logic [ADDR_W-1:0]  next_q;
    logic [WORD_W-1:0]  status_q;
    logic [WORD_W-1:0]  word_q;
    logic [LEN_W-1:0]   seg_len;
    logic [LEN_W-1:0]   byte_idx;
    logic               seg_first;
    logic               seg_last;
    logic               at_end;

    assign at_end = (byte_idx == seg_len - LEN_W'(1));

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur;
        mem_wdata = status_q & ~OWN_MASK;
        unique case (state)
            W_RD_STAT: mem_req = 1'b1;
            W_RD_CTRL: begin mem_req = 1'b1; mem_addr = cur + ADDR_W'(4);  end
            W_RD_BUF:  begin mem_req = 1'b1; mem_addr = cur + ADDR_W'(8);  end
            W_RD_NEXT: begin mem_req = 1'b1; mem_addr = cur + ADDR_W'(12); end
            W_RD_DATA: begin
                mem_req  = 1'b1;
                mem_addr = buf_q + ADDR_W'({byte_idx[LEN_W-1:2], 2'b00});
            end
            W_WB:      begin mem_req = 1'b1; mem_we = 1'b1; end
            default:   ;
        endcase
    end

    assign push           = (state == W_PUSH) && !q_full;
    assign push_ent.data  = lane_byte(word_q, byte_idx[1:0]);
    assign push_ent.first = seg_first && (byte_idx == '0);
    assign push_ent.last  = seg_last && at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= W_IDLE;
            cur       <= '0;
            buf_q     <= '0;
            next_q    <= '0;
            status_q  <= '0;
            word_q    <= '0;
            seg_len   <= '0;
            byte_idx  <= '0;
            seg_first <= 1'b0;
            seg_last  <= 1'b0;
        end else begin
            unique case (state)
                W_IDLE: if (start) begin
                    cur   <= base;
                    state <= W_RD_STAT;
                end
                W_RD_STAT: if (mem_ack) begin
                    status_q <= mem_rdata;
                    state    <= mem_rdata[OWN_BIT] ? W_RD_CTRL : W_SUSP;
                end
                W_RD_CTRL: if (mem_ack) begin
                    seg_len   <= mem_rdata[LEN_W-1:0];
                    seg_first <= mem_rdata[SEG_FIRST_BIT];
                    seg_last  <= mem_rdata[SEG_LAST_BIT];
                    state     <= mem_rdata[SEG_ENA_BIT] ? W_RD_BUF : W_SUSP;
                end
                W_RD_BUF: if (mem_ack) begin
                    buf_q <= mem_rdata[ADDR_W-1:0];
                    state <= W_RD_NEXT;
                end
                W_RD_NEXT: if (mem_ack) begin
                    next_q   <= mem_rdata[ADDR_W-1:0];
                    byte_idx <= '0;
                    state    <= (seg_len == '0) ? W_WB : W_RD_DATA;
                end
                W_RD_DATA: if (mem_ack) begin
                    word_q <= mem_rdata;
                    state  <= W_PUSH;
                end
                W_PUSH: if (!q_full) begin
                    byte_idx <= byte_idx + LEN_W'(1);
                    if (at_end)                      state <= W_WB;
                    else if (byte_idx[1:0] == 2'b11) state <= W_RD_DATA;
                end
                W_WB: if (mem_ack) begin
                    cur   <= next_q;
                    state <= run ? W_RD_STAT : W_IDLE;
                end
                W_SUSP: begin
                    if (!run)      state <= W_IDLE;
                    else if (kick) state <= W_RD_STAT;
                end
                default: state <= W_IDLE;
            endcase
        end
    end

    // R12: an unanswered request stays put
    assert_req_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R3: control is only fetched for an owned descriptor
    assert_owned_before_ctrl_R3: assert property (@(posedge clk) disable iff (rst)
        (state == W_RD_CTRL) |-> status_q[OWN_BIT]);

    // R8: write-back only once the whole segment has been queued
    assert_wb_after_segment_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (byte_idx == seg_len));

endmodule

// File: rtl/txd_outq.sv
module txd_outq
    import txd_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sf_mode,
    input  logic       push,
    input  tx_ent_t    push_ent,
    output logic       q_full,
    output logic       tx_valid,
    input  logic       tx_ready,
    output logic [7:0] tx_data,
    output logic       tx_first,
    output logic       tx_last
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    tx_ent_t          store [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] frames;
    tx_ent_t          head;
    logic             pop;

    assign head     = store[rd_ptr];
    assign q_full   = (count == CNT_W'(DEPTH));
    assign tx_valid = (count != '0) && (!sf_mode || (frames != '0));
    assign pop      = tx_valid && tx_ready;
    assign tx_data  = head.data;
    assign tx_first = head.first;
    assign tx_last  = head.last;

    always_ff @(posedge clk) begin
        if (push) store[wr_ptr] <= push_ent;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            frames <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + PTR_W'(1);
            if (pop)  rd_ptr <= rd_ptr + PTR_W'(1);
            count  <= count + CNT_W'(push) - CNT_W'(pop);
            frames <= frames + CNT_W'(push && push_ent.last) - CNT_W'(pop && head.last);
        end
    end

    // R6: the walker never pushes into a full queue
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        push |-> (count < CNT_W'(DEPTH)));

    // R11: an offered byte is held until taken
    assert_stream_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_first) && $stable(tx_last)));

endmodule

// File: rtl/txdma_fetch.sv
module txdma_fetch
    import txd_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 12,
    parameter int FIFO_DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [31:0]       cfg_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_first,
    output logic              tx_last
);

    logic              run;
    logic              sf_mode;
    logic              kick;
    logic              start;
    logic [ADDR_W-1:0] base;
    logic              push;
    tx_ent_t           push_ent;
    logic              q_full;

    txd_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .run       (run),
        .sf_mode   (sf_mode),
        .kick      (kick),
        .start     (start),
        .base      (base)
    );

    txd_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_walker (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .start     (start),
        .kick      (kick),
        .base      (base),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .push      (push),
        .push_ent  (push_ent),
        .q_full    (q_full)
    );

    txd_outq #(.DEPTH(FIFO_DEPTH)) u_outq (
        .clk      (clk),
        .rst      (rst),
        .sf_mode  (sf_mode),
        .push     (push),
        .push_ent (push_ent),
        .q_full   (q_full),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .tx_data  (tx_data),
        .tx_first (tx_first),
        .tx_last  (tx_last)
    );

endmodule

// File: tb/sim_txdma_fetch.sv
`timescale 1ns/1ps
module sim_txdma_fetch;

    localparam int MEM_WORDS = 1024;
    localparam int BUF_BASE  = 32'h400;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr, cfg_sel;
    logic [31:0] cfg_wdata;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        tx_valid, tx_ready, tx_first, tx_last;
    logic [7:0]  tx_data;

    always #4 clk = ~clk;

    txdma_fetch u0 (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_first(tx_first), .tx_last(tx_last)
    );

    logic [31:0] mem [MEM_WORDS];
    int rd_cnt [MEM_WORDS];
    int wr_cnt [MEM_WORDS];
    int n_cmp = 0, n_bad = 0;
    int cyc = 0;
    int lat_fixed = -1;
    bit ready_always = 1'b0;
    int req_viol = 0, hold_viol = 0;
    int last_buf_ack = 0, first_cyc = -1;
    int first_rd_addr = -1;
    bit first_rd_pending = 1'b0;
    bit done_flag = 1'b0;
    logic [7:0] exp_d [4096]; bit exp_f [4096]; bit exp_l [4096]; int exp_n = 0;
    logic [7:0] rx_d [4096];  bit rx_f [4096];  bit rx_l [4096];  int rx_n = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] ctlw(input bit run, input bit sf, input bit kick);
        return (32'(kick) << 31) | (32'(run) << 30) | (32'(sf) << 1);
    endfunction
    function automatic logic [31:0] segctl(input bit ena, input bit f, input bit l, input int len);
        return (32'(l) << 30) | (32'(f) << 29) | (32'(ena) << 24) | (32'(len) & 32'hFFF);
    endfunction
    function automatic int daddr(input int slot); return slot * 16; endfunction
    function automatic int baddr(input int slot); return BUF_BASE + (slot % 24) * 128; endfunction
    function automatic logic [31:0] returned(input logic [31:0] s); return s & 32'h7FFF_FFFF; endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic summary();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // memory responder with optional latency
    initial begin : responder
        int wait_left = 0, idx;
        bit pend = 1'b0; logic [31:0] p_addr; logic p_we;
        mem_ack = 1'b0; mem_rdata = '0; p_addr = '0; p_we = 1'b0;
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (rst) begin pend = 1'b0; continue; end
            if (mem_req) begin
                if (pend && (mem_addr != p_addr || mem_we != p_we)) req_viol++;
                if (wait_left > 0) begin
                    wait_left--; pend = 1'b1; p_addr = mem_addr; p_we = mem_we;
                end else begin
                    idx = int'(mem_addr[11:2]);
                    if (mem_we) begin
                        mem[idx] = mem_wdata; wr_cnt[idx]++;
                    end else begin
                        mem_rdata = mem[idx]; rd_cnt[idx]++;
                        if (int'(mem_addr) >= BUF_BASE) last_buf_ack = cyc;
                        if (first_rd_pending) begin first_rd_addr = int'(mem_addr); first_rd_pending = 1'b0; end
                    end
                    mem_ack = 1'b1; pend = 1'b0;
                    wait_left = (lat_fixed < 0) ? int'($urandom % 4) : lat_fixed;
                end
            end else begin
                if (pend) req_viol++;
                pend = 1'b0;
            end
        end
    end

    // stream sink and monitor
    initial begin : sink
        bit h_pend = 1'b0; logic [7:0] h_d; bit h_f, h_l;
        tx_ready = 1'b0; h_d = '0; h_f = 1'b0; h_l = 1'b0;
        forever begin
            @(negedge clk);
            if (rst) begin h_pend = 1'b0; continue; end
            if (h_pend && (!tx_valid || tx_data != h_d || tx_first != h_f || tx_last != h_l)) hold_viol++;
            tx_ready = ready_always ? 1'b1 : (($urandom % 4) != 0);
            #1;
            if (tx_valid && tx_ready) begin
                if (rx_n == 0) first_cyc = cyc;
                rx_d[rx_n] = tx_data; rx_f[rx_n] = tx_first; rx_l[rx_n] = tx_last; rx_n++;
            end
            h_pend = tx_valid && !tx_ready; h_d = tx_data; h_f = tx_first; h_l = tx_last;
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
    end

    task automatic cfg_write(input bit sel, input logic [31:0] d);
        @(negedge clk); cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic put_desc(input int slot, input logic [31:0] st, input logic [31:0] ctl, input int nxt_slot);
        int a; a = daddr(slot) >> 2;
        mem[a] = st; mem[a+1] = ctl; mem[a+2] = 32'(baddr(slot)); mem[a+3] = 32'(daddr(nxt_slot));
    endtask

    // fill buffer with random bytes; when expected, record them
    task automatic fill_buf(input int slot, input int len, input bit f, input bit l, input bit expect_out);
        int b; logic [7:0] v;
        for (int i = 0; i < len; i++) begin
            b = baddr(slot) + i; v = 8'($urandom);
            mem[b >> 2][8*(b % 4) +: 8] = v;
            if (expect_out) begin
                exp_d[exp_n] = v; exp_f[exp_n] = f && (i == 0); exp_l[exp_n] = l && (i == len - 1); exp_n++;
            end
        end
    endtask

    task automatic clear_log();
        for (int i = 0; i < MEM_WORDS; i++) begin rd_cnt[i] = 0; wr_cnt[i] = 0; end
        rx_n = 0; exp_n = 0; first_cyc = -1;
    endtask

    task automatic wait_done(input string req);
        int quiet = 0, t = 0;
        while (quiet < 30 && t < 20000) begin
            @(negedge clk); #2; t++;
            if (!mem_req && !tx_valid) quiet++; else quiet = 0;
        end
        chk(quiet >= 30, req, "engine settles (cycles)", t, 0);
    endtask

    task automatic check_stream();
        chk(rx_n == exp_n, "R6", "byte count", rx_n, exp_n);
        for (int i = 0; i < rx_n && i < exp_n; i++) begin
            chk(rx_d[i] == exp_d[i], "R6", "byte value", int'(rx_d[i]), int'(exp_d[i]));
            chk(rx_f[i] == exp_f[i] && rx_l[i] == exp_l[i], "R7", "markers {first,last}",
                int'({rx_f[i], rx_l[i]}), int'({exp_f[i], exp_l[i]}));
        end
    endtask

    initial begin : main
        bit ok;
        logic [31:0] st_orig [8];
        void'($urandom(32'h5EED_7A3C));
        cfg_wr = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
        for (int i = 0; i < MEM_WORDS; i++) begin mem[i] = '0; rd_cnt[i] = 0; wr_cnt[i] = 0; end
        rst = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1: quiet after reset
        ok = 1'b1;
        repeat (20) begin @(negedge clk); #2; if (mem_req || tx_valid) ok = 1'b0; end
        chk(ok, "R1", "no request or valid after reset", int'(ok), 1);

        // R10: store-and-forward timing, single 48-byte frame, slow memory
        lat_fixed = 3; ready_always = 1'b1;
        for (int m = 0; m < 2; m++) begin
            bit sf; int s;
            sf = (m == 0); s = 1 + m;
            cfg_write(0, ctlw(0, sf, 0));
            cfg_write(1, 32'(daddr(s)));
            clear_log();
            put_desc(s, 32'h8000_0000, segctl(1, 1, 1, 48), s);
            fill_buf(s, 48, 1, 1, 1);
            cfg_write(0, ctlw(1, sf, 0));
            wait_done("R10");
            check_stream();
            if (sf) chk(first_cyc > last_buf_ack, "R10", "store-forward first byte after last fetch", first_cyc, last_buf_ack);
            else    chk(first_cyc < last_buf_ack, "R10", "cut-through first byte before last fetch", first_cyc, last_buf_ack);
        end

        // R3, R4, R5: parking, kick, enable flag
        lat_fixed = -1; ready_always = 1'b0;
        cfg_write(0, ctlw(0, 0, 0));
        cfg_write(1, 32'(daddr(4)));
        clear_log();
        put_desc(4, 32'h8000_0011, segctl(1, 1, 1, 13), 5);
        fill_buf(4, 13, 1, 1, 1);
        put_desc(5, 32'h0000_0022, segctl(1, 1, 1, 9), 4);
        cfg_write(0, ctlw(1, 0, 0));
        wait_done("R3");
        check_stream();
        chk(rd_cnt[daddr(5) >> 2] == 1, "R3", "unowned: status reads", rd_cnt[daddr(5) >> 2], 1);
        chk(rd_cnt[(daddr(5) >> 2) + 1] == 0, "R3", "unowned: control reads", rd_cnt[(daddr(5) >> 2) + 1], 0);
        chk(wr_cnt[daddr(5) >> 2] == 0, "R3", "unowned: writes", wr_cnt[daddr(5) >> 2], 0);
        chk(mem[daddr(4) >> 2] == 32'h0000_0011, "R8", "status written back", int'(mem[daddr(4) >> 2]), 32'h11);

        clear_log();
        put_desc(5, 32'h8000_0022, segctl(0, 1, 1, 9), 4);
        fill_buf(5, 9, 1, 1, 0);
        repeat (40) @(negedge clk);
        chk(rd_cnt[daddr(5) >> 2] == 0, "R4", "no access while parked without kick", rd_cnt[daddr(5) >> 2], 0);
        cfg_write(0, ctlw(1, 0, 1));
        wait_done("R5");
        chk(rx_n == 0, "R5", "disabled descriptor emits nothing", rx_n, 0);
        chk(rd_cnt[daddr(5) >> 2] == 1, "R4", "kick re-reads status", rd_cnt[daddr(5) >> 2], 1);
        chk(rd_cnt[(daddr(5) >> 2) + 1] == 1, "R5", "disabled: control read once", rd_cnt[(daddr(5) >> 2) + 1], 1);
        chk(rd_cnt[(daddr(5) >> 2) + 2] == 0, "R5", "disabled: buffer pointer not read", rd_cnt[(daddr(5) >> 2) + 2], 0);
        chk(mem[daddr(5) >> 2] == 32'h8000_0022, "R5", "disabled: status unchanged", int'(mem[daddr(5) >> 2]), 32'h8000_0022);

        clear_log();
        put_desc(5, 32'h8000_0022, segctl(1, 1, 1, 9), 4);
        fill_buf(5, 9, 1, 1, 1);
        cfg_write(0, ctlw(1, 0, 1));
        wait_done("R4");
        check_stream();
        chk(mem[daddr(5) >> 2] == 32'h0000_0022, "R4", "kicked descriptor returned", int'(mem[daddr(5) >> 2]), 32'h22);
        chk(rd_cnt[daddr(4) >> 2] == 1, "R9", "next pointer followed to head", rd_cnt[daddr(4) >> 2], 1);

        // R13: stop at descriptor boundary
        cfg_write(0, ctlw(0, 0, 0));
        cfg_write(1, 32'(daddr(6)));
        clear_log();
        put_desc(6, 32'h8000_0A0A, segctl(1, 1, 1, 27), 7);
        fill_buf(6, 27, 1, 1, 1);
        put_desc(7, 32'h8000_0B0B, segctl(1, 1, 1, 5), 6);
        fill_buf(7, 5, 1, 1, 0);
        cfg_write(0, ctlw(1, 0, 0));
        cfg_write(0, ctlw(0, 0, 0));
        wait_done("R13");
        check_stream();
        chk(mem[daddr(6) >> 2] == 32'h0000_0A0A, "R13", "current segment finished", int'(mem[daddr(6) >> 2]), 32'hA0A);
        chk(rd_cnt[daddr(7) >> 2] == 0, "R13", "next descriptor not read", rd_cnt[daddr(7) >> 2], 0);
        chk(mem[daddr(7) >> 2] == 32'h8000_0B0B, "R13", "next descriptor still owned", int'(mem[daddr(7) >> 2]), 32'h8000_0B0B);

        // random chains in both modes
        for (int r = 0; r < 6; r++) begin
            int n, s0, seg, len; bit sf, f, l;
            sf = r[0]; n = 2 + int'($urandom % 4); s0 = 10 + r * 6; seg = 0;
            cfg_write(0, ctlw(0, sf, 0));
            cfg_write(1, 32'(daddr(s0)));
            clear_log();
            for (int k = 0; k < n; k++) begin
                f = (seg == 0);
                l = (k == n - 1) || (seg == 2) || (($urandom % 2) == 0);
                len = 1 + int'($urandom % 20);
                st_orig[k] = 32'h8000_0000 | ($urandom & 32'h7FFF_FFFF);
                put_desc(s0 + k, st_orig[k], segctl(1, f, l, len), (k == n - 1) ? s0 : s0 + k + 1);
                fill_buf(s0 + k, len, f, l, 1);
                seg = l ? 0 : seg + 1;
            end
            first_rd_pending = 1'b1;
            cfg_write(0, ctlw(1, sf, 0));
            wait_done("R9");
            check_stream();
            chk(first_rd_addr == daddr(s0), "R2", "first read at base address", first_rd_addr, daddr(s0));
            for (int k = 0; k < n; k++)
                chk(mem[daddr(s0 + k) >> 2] == returned(st_orig[k]), "R8", "status write-back",
                    int'(mem[daddr(s0 + k) >> 2]), int'(returned(st_orig[k])));
            chk(rd_cnt[daddr(s0) >> 2] == 2, "R9", "loop returns to head", rd_cnt[daddr(s0) >> 2], 2);
        end

        chk(hold_viol == 0, "R11", "stream held under back-pressure", hold_viol, 0);
        chk(req_viol == 0, "R12", "request held until acknowledged", req_viol, 0);
        summary();
    end

endmodule